// File: doc/BRIEF.md
# Software-Triggered Clock-Domain Configuration Transfer

This block keeps three configuration words in a fast bus clock domain: a control word, a wakeup enable mask and a reset enable mask. It delivers them to logic in a slow always-on clock domain only when software asks. Software can write the three words as often as it likes, and the slow side keeps its previous copy. To move the words across, software writes one to a trigger bit. It then polls that bit until it reads zero again, and from then on the slow outputs hold the values programmed at the moment of the trigger.

A toggle carries the transfer request across. It passes through a two-flop synchronizer into the slow domain, and a second toggle returns the acknowledge the same way. At the trigger the fast side freezes a snapshot of the three words. The slow side loads that snapshot in the one cycle where it sees the synchronized request change. Writes made while a transfer is in flight therefore wait for the next trigger.

Top module: `cdc_cfg_sync`

## Requirements
- R1: After reset, all three configuration words and the trigger bit read zero on the fast side, and the three slow-domain outputs are zero.
- R2: Writing the control, wakeup or reset words (address 0, 1, 2) leaves the slow-domain outputs unchanged as long as no transfer is triggered.
- R3: A write with address 3 and data bit 0 set starts a transfer. When it completes, the slow outputs equal the three words held in the fast registers at the trigger write.
- R4: The trigger bit (bit 0 at address 3) reads one from the cycle after a starting write until the acknowledge has returned to the fast domain. It then reads zero without any software action.
- R5: Configuration writes made while a transfer is in flight do not reach the slow outputs through that transfer. The fast-side snapshot stays frozen until the acknowledge returns.
- R6: A trigger write made while a transfer is in flight has no effect, and so does a write to address 3 with bit 0 clear. Neither starts a further transfer.
- R7: Reads of address 0, 1 and 2 return the stored control, wakeup and reset words, zero-extended to the data width. A read of address 3 returns the trigger bit in bit 0 and zeros above it.
- R8: The slow outputs change only on the slow clock edge that follows a detected change of the synchronized request toggle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Fast bus clock |
| rst_fast_ni | input | 1 | Fast-domain reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register address: 0 control, 1 wakeup mask, 2 reset mask, 3 trigger |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Combinational read data for addr_i |
| clk_slow_i | input | 1 | Slow always-on clock |
| rst_slow_ni | input | 1 | Slow-domain reset, active low |
| slow_ctrl_o | output | CTRL_W | Control word in the slow domain |
| slow_wake_en_o | output | WAKE_W | Wakeup enable mask in the slow domain |
| slow_rst_en_o | output | RST_W | Reset enable mask in the slow domain |

## Verification
A table of configuration sets is pushed through one transfer each. The sets include all-ones patterns, a return to all zeros and mixed bit patterns. Together they show that every field lands in its own output, and that the outputs hold their old values between writes and trigger. A directed sequence rewrites the control word and retriggers while a transfer is still in flight. This separates a design that snapshots at the trigger from one that passes live registers across, and a design that ignores an early trigger from one that queues it. A trigger write with bit 0 clear and the register readback complete the set.

// File: rtl/cfgsync_pkg.sv
package cfgsync_pkg;

  typedef enum logic [1:0] {
    ADDR_CTRL = 2'd0,
    ADDR_WAKE = 2'd1,
    ADDR_RST  = 2'd2,
    ADDR_SYNC = 2'd3
  } cfg_addr_e;

  // A transfer is outstanding while the request toggle and the returned
  // acknowledge toggle disagree.
  function automatic logic xfer_pending(input logic req_tgl, input logic ack_tgl);
    return req_tgl ^ ack_tgl;
  endfunction

  // Change of a synchronized toggle against its registered copy.
  function automatic logic toggle_seen(input logic now_v, input logic prev_v);
    return now_v ^ prev_v;
  endfunction

endpackage

// File: rtl/cfgsync_sync2.sv
module cfgsync_sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage1_q;
  logic [W-1:0] stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/cfgsync_fast.sv
module cfgsync_fast
  import cfgsync_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CTRL_W = 8,
  parameter int WAKE_W = 5,
  parameter int RST_W  = 2,
  localparam int PAY_W = CTRL_W + WAKE_W + RST_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              ack_sync_i,
  output logic              req_tgl_o,
  output logic              busy_o,
  output logic              sync_wr_o,
  output logic [PAY_W-1:0]  snap_o
);
  logic [CTRL_W-1:0] ctrl_q;
  logic [WAKE_W-1:0] wake_q;
  logic [RST_W-1:0]  rst_q;
  logic              req_q;
  logic [PAY_W-1:0]  snap_q;
  logic              busy;
  logic              sync_wr;
  logic              start;

  assign busy    = xfer_pending(req_q, ack_sync_i);
  assign sync_wr = wr_en_i && (cfg_addr_e'(addr_i) == ADDR_SYNC) && wdata_i[0];
  assign start   = sync_wr && !busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      wake_q <= '0;
      rst_q  <= '0;
    end else if (wr_en_i) begin
      case (cfg_addr_e'(addr_i))
        ADDR_CTRL: ctrl_q <= wdata_i[CTRL_W-1:0];
        ADDR_WAKE: wake_q <= wdata_i[WAKE_W-1:0];
        ADDR_RST:  rst_q  <= wdata_i[RST_W-1:0];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= 1'b0;
      snap_q <= '0;
    end else if (start) begin
      req_q  <= ~req_q;
      snap_q <= {ctrl_q, wake_q, rst_q};
    end
  end

  always_comb begin
    rdata_o = '0;
    case (cfg_addr_e'(addr_i))
      ADDR_CTRL: rdata_o[CTRL_W-1:0] = ctrl_q;
      ADDR_WAKE: rdata_o[WAKE_W-1:0] = wake_q;
      ADDR_RST:  rdata_o[RST_W-1:0]  = rst_q;
      default:   rdata_o[0]          = busy;
    endcase
  end

  assign req_tgl_o = req_q;
  assign busy_o    = busy;
  assign sync_wr_o = sync_wr;
  assign snap_o    = snap_q;
endmodule

// File: rtl/cfgsync_slow.sv
module cfgsync_slow
  import cfgsync_pkg::*;
#(
  parameter int PAY_W = 15
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_sync_i,
  input  logic [PAY_W-1:0] snap_i,
  output logic             ack_tgl_o,
  output logic             cap_pulse_o,
  output logic [PAY_W-1:0] pay_o
);
  logic             req_seen_q;
  logic [PAY_W-1:0] pay_q;
  logic             cap_pulse;

  assign cap_pulse = toggle_seen(req_sync_i, req_seen_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_seen_q <= 1'b0;
      pay_q      <= '0;
    end else begin
      req_seen_q <= req_sync_i;
      if (cap_pulse) pay_q <= snap_i;
    end
  end

  assign ack_tgl_o   = req_seen_q;
  assign cap_pulse_o = cap_pulse;
  assign pay_o       = pay_q;
endmodule

// File: rtl/cdc_cfg_sync.sv
module cdc_cfg_sync #(
  parameter int DATA_W = 16,
  parameter int CTRL_W = 8,
  parameter int WAKE_W = 5,
  parameter int RST_W  = 2,
  localparam int PAY_W = CTRL_W + WAKE_W + RST_W
) (
  input  logic              clk_fast_i,
  input  logic              rst_fast_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              clk_slow_i,
  input  logic              rst_slow_ni,
  output logic [CTRL_W-1:0] slow_ctrl_o,
  output logic [WAKE_W-1:0] slow_wake_en_o,
  output logic [RST_W-1:0]  slow_rst_en_o
);
  logic             req_tgl;
  logic             req_sync;
  logic             ack_tgl;
  logic             ack_sync;
  logic             busy;
  logic             sync_wr;
  logic             cap_pulse;
  logic [PAY_W-1:0] snap;
  logic [PAY_W-1:0] pay_q;

  cfgsync_fast #(
    .DATA_W(DATA_W), .CTRL_W(CTRL_W), .WAKE_W(WAKE_W), .RST_W(RST_W)
  ) u_fast (
    .clk_i      (clk_fast_i),
    .rst_ni     (rst_fast_ni),
    .wr_en_i    (wr_en_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .rdata_o    (rdata_o),
    .ack_sync_i (ack_sync),
    .req_tgl_o  (req_tgl),
    .busy_o     (busy),
    .sync_wr_o  (sync_wr),
    .snap_o     (snap)
  );

  cfgsync_sync2 #(.W(1)) u_req_sync (
    .clk_i  (clk_slow_i),
    .rst_ni (rst_slow_ni),
    .d_i    (req_tgl),
    .q_o    (req_sync)
  );

  cfgsync_slow #(.PAY_W(PAY_W)) u_slow (
    .clk_i       (clk_slow_i),
    .rst_ni      (rst_slow_ni),
    .req_sync_i  (req_sync),
    .snap_i      (snap),
    .ack_tgl_o   (ack_tgl),
    .cap_pulse_o (cap_pulse),
    .pay_o       (pay_q)
  );

  cfgsync_sync2 #(.W(1)) u_ack_sync (
    .clk_i  (clk_fast_i),
    .rst_ni (rst_fast_ni),
    .d_i    (ack_tgl),
    .q_o    (ack_sync)
  );

  assign slow_ctrl_o    = pay_q[PAY_W-1 -: CTRL_W];
  assign slow_wake_en_o = pay_q[RST_W +: WAKE_W];
  assign slow_rst_en_o  = pay_q[RST_W-1:0];
endmodule

// File: rtl/cfgsync_chk.sv
module cfgsync_chk #(
  parameter int PAY_W = 15
) (
  input logic             clk_fast_i,
  input logic             rst_fast_ni,
  input logic             clk_slow_i,
  input logic             rst_slow_ni,
  input logic             sync_wr,
  input logic             busy,
  input logic             req_tgl,
  input logic [PAY_W-1:0] snap,
  input logic             cap_pulse,
  input logic [PAY_W-1:0] pay_q
);
  // R4
  busy_rise_after_trigger_chk: assert property (@(posedge clk_fast_i) disable iff (!rst_fast_ni)
    $rose(busy) |-> $past(sync_wr));

  // R6
  retrigger_ignored_chk: assert property (@(posedge clk_fast_i) disable iff (!rst_fast_ni)
    (sync_wr && busy) |=> $stable(req_tgl));

  // R5
  snapshot_frozen_chk: assert property (@(posedge clk_fast_i) disable iff (!rst_fast_ni)
    busy |=> $stable(snap));

  // R8
  outputs_hold_chk: assert property (@(posedge clk_slow_i) disable iff (!rst_slow_ni)
    !$past(cap_pulse) |-> $stable(pay_q));

  // R3
  capture_value_chk: assert property (@(posedge clk_slow_i) disable iff (!rst_slow_ni)
    cap_pulse |=> (pay_q == snap));
endmodule

bind cdc_cfg_sync cfgsync_chk #(.PAY_W(PAY_W)) u_chk (
  .clk_fast_i  (clk_fast_i),
  .rst_fast_ni (rst_fast_ni),
  .clk_slow_i  (clk_slow_i),
  .rst_slow_ni (rst_slow_ni),
  .sync_wr     (sync_wr),
  .busy        (busy),
  .req_tgl     (req_tgl),
  .snap        (snap),
  .cap_pulse   (cap_pulse),
  .pay_q       (pay_q)
);

// File: tb/tb_cdc_cfg_sync.sv
module tb_cdc_cfg_sync;
  localparam int CLK_PERIOD  = 10;
  localparam int SLOW_PERIOD = 46;
  localparam int DATA_W = 16;
  localparam int CTRL_W = 8;
  localparam int WAKE_W = 5;
  localparam int RST_W  = 2;
  localparam int NVEC   = 4;

  // each entry: {control, wakeup mask, reset mask}
  localparam logic [14:0] VEC [NVEC] = '{
    {8'hA5, 5'h1F, 2'b11},
    {8'h00, 5'h00, 2'b00},
    {8'h3C, 5'h0A, 2'b01},
    {8'hFF, 5'h15, 2'b10}
  };

  logic clk_f = 1'b0;
  logic clk_s = 1'b0;
  logic rst_f_n = 1'b0;
  logic rst_s_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic [CTRL_W-1:0] s_ctrl;
  logic [WAKE_W-1:0] s_wake;
  logic [RST_W-1:0]  s_rst;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk_f = ~clk_f;
  always #(SLOW_PERIOD/2) clk_s = ~clk_s;

  cdc_cfg_sync #(.DATA_W(DATA_W), .CTRL_W(CTRL_W), .WAKE_W(WAKE_W), .RST_W(RST_W)) dut (
    .clk_fast_i(clk_f), .rst_fast_ni(rst_f_n), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .clk_slow_i(clk_s), .rst_slow_ni(rst_s_n),
    .slow_ctrl_o(s_ctrl), .slow_wake_en_o(s_wake), .slow_rst_en_o(s_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk_f);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk_f);
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk_f);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk_f);
  endtask

  task automatic wait_done(input string req);
    logic [DATA_W-1:0] v;
    int n;
    n = 0;
    rd(2'd3, v);
    while (v[0] && n < 500) begin
      rd(2'd3, v);
      n++;
    end
    check(req, {31'd0, v[0]}, 32'd0);
  endtask

  task automatic check_out(input string req, input logic [14:0] exp);
    check(req, {17'd0, s_ctrl, s_wake, s_rst}, {17'd0, exp});
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [DATA_W-1:0] v;
    logic [14:0] prev;
    idle(3);
    rst_f_n = 1'b1; rst_s_n = 1'b1;
    idle(3);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check("R1", {16'd0, v}, 32'd0);
    end
    check_out("R1", 15'd0);

    // table walk
    prev = 15'd0;
    for (int i = 0; i < NVEC; i++) begin
      wr(2'd0, {8'd0, VEC[i][14:7]});
      wr(2'd1, {11'd0, VEC[i][6:2]});
      wr(2'd2, {14'd0, VEC[i][1:0]});
      idle(40);
      check_out("R2", prev);
      rd(2'd0, v); check("R7", {16'd0, v}, {24'd0, VEC[i][14:7]});
      rd(2'd1, v); check("R7", {16'd0, v}, {27'd0, VEC[i][6:2]});
      rd(2'd2, v); check("R7", {16'd0, v}, {30'd0, VEC[i][1:0]});
      wr(2'd3, 16'h0001);
      rd(2'd3, v); check("R4", {16'd0, v}, 32'd1);
      wait_done("R4");
      check_out("R3", VEC[i]);
      prev = VEC[i];
    end

    // in-flight writes and retrigger
    wr(2'd0, 16'h0011);
    wr(2'd3, 16'h0001);
    wr(2'd0, 16'h0077);
    rd(2'd3, v); check("R4", {16'd0, v}, 32'd1);
    wr(2'd3, 16'h0001);
    wait_done("R4");
    check_out("R5", {8'h11, VEC[NVEC-1][6:0]});
    idle(300);
    check_out("R6", {8'h11, VEC[NVEC-1][6:0]});
    rd(2'd3, v); check("R6", {16'd0, v}, 32'd0);
    rd(2'd0, v); check("R7", {16'd0, v}, 32'h77);

    // write of zero to trigger does nothing
    wr(2'd3, 16'h0000);
    rd(2'd3, v); check("R6", {16'd0, v}, 32'd0);
    idle(300);
    check_out("R6", {8'h11, VEC[NVEC-1][6:0]});

    // final transfer picks up the pending value
    wr(2'd3, 16'h0001);
    wait_done("R4");
    check_out("R3", {8'h77, VEC[NVEC-1][6:0]});

    summary();
  end
endmodule